// File: doc/BRIEF.md
# Flash Query-Mode Command Responder

This block stands in for the command decoder and read multiplexer of a byte-wide parallel NOR flash, as seen by host software that interrogates the device before it uses it. On every clock where the write strobe is high, it reads the address and data bus as a command write. It keeps track of one of three modes: plain array reads, identifier reads reached through an unlock sequence, and query reads that serve a fixed table describing the device's command set, supply window and operation timeouts.

Reads have no strobe. The read-data output always reflects the current mode and the current address. In array mode it forwards an external array data port. In identifier mode it returns two placeholder identifier bytes. In query mode it returns table bytes. When query mode is entered, the block records whether the entry came from identifier mode, so the reset command can go back to the mode the host left.

Top module: `cfi_query_resp`

## Requirements
- R1: After reset the block is in array mode, and `rdData` equals `arrayData` in the same cycle.
- R2: From array mode, a write of 98h to address 055h switches to query mode. A read in the next cycle returns query data. A write of 98h to any other address has no effect.
- R3: From identifier mode, a write of 98h to address 055h switches to query mode.
- R4: A write of F0h to any address is the reset command in every mode. From query mode it returns to identifier mode if query mode was entered from identifier mode, and to array mode otherwise. From the other modes it returns to array mode.
- R5: In query mode, addresses 10h, 11h and 12h read 51h, 52h and 59h. Addresses 13h and 14h read 02h and 00h. Addresses 15h and 16h read 40h and 00h. Addresses 17h through 1Ah read 00h.
- R6: In query mode, address 1Bh reads 27h and 1Ch reads 36h. In each of these bytes the upper nibble gives volts and the lower nibble gives tenths of a volt. Addresses 1Dh and 1Eh read 00h.
- R7: In query mode, addresses 1Fh through 26h read 04h, 00h, 0Ah, 00h, 05h, 00h, 04h, 00h in that order.
- R8: In query mode, every address outside 10h–26h reads 00h.
- R9: From array mode, the writes AAh at 555h, 55h at 2AAh and 90h at 555h, in that order, enter identifier mode. Any other write part-way through clears the partial sequence. In identifier mode, an even address reads `MFG_ID` (default 01h) and an odd address reads `DEV_ID` (default C8h).
- R10: In query mode, every write other than F0h is ignored, including 98h at 055h and the unlock writes.
- R11: A read in the same cycle as a mode-changing write still returns data from the old mode. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (11) | Host address for reads and command writes |
| busWrData | input | DATA_W (8) | Host write data (command byte) |
| busWe | input | 1 | Write strobe; one write per clock when high |
| arrayData | input | DATA_W (8) | Data from the storage array for array-mode reads |
| rdData | output | DATA_W (8) | Read data for the current mode and address |

## Verification
A command write and a read can fall in the same cycle, because the read path is combinational and the strobe applies on the clock edge. The bench provokes this by checking `rdData` in every write cycle, including the cycles that enter or leave query mode. It expects the old mode's data in that cycle and the new mode's data in the next one. A second collision is the reset command arriving part-way through the unlock sequence, where the reset command must win and the partial sequence must be lost.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_QUERY = 2'd2
  } cfiMode_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_ONE  = 2'd1,
    UL_TWO  = 2'd2
  } unlockStep_e;

  // strobes from control to datapath, exactly one set at a time
  typedef struct packed {
    logic selArray;
    logic selAuto;
    logic selQuery;
  } readSel_t;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_UL1   = 8'hAA;
  localparam logic [7:0] CMD_UL2   = 8'h55;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
endpackage

// File: rtl/cfi_ctrl.sv
module cfi_ctrl
  import cfi_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWe,
  output cfiMode_e          curMode,
  output readSel_t          readSel
);
  localparam logic [ADDR_W-1:0] ADDR_QRY = ADDR_W'(12'h055);
  localparam logic [ADDR_W-1:0] ADDR_UA  = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADDR_UB  = ADDR_W'(12'h2AA);

  cfiMode_e    modeQ, modeD;
  unlockStep_e stepQ, stepD;
  logic        fromAutoQ, fromAutoD;

  logic isReset, isQuery;
  assign isReset = busWrData == DATA_W'(CMD_RESET);
  assign isQuery = (busWrData == DATA_W'(CMD_QUERY)) && (busAddr == ADDR_QRY);

  always_comb begin
    modeD     = modeQ;
    stepD     = stepQ;
    fromAutoD = fromAutoQ;
    if (busWe) begin
      if (isReset) begin
        modeD = (modeQ == MODE_QUERY && fromAutoQ) ? MODE_AUTO : MODE_ARRAY;
        stepD = UL_IDLE;
        fromAutoD = 1'b0;
      end else begin
        unique case (modeQ)
          MODE_ARRAY: begin
            if (isQuery) begin
              modeD = MODE_QUERY;
              fromAutoD = 1'b0;
              stepD = UL_IDLE;
            end else begin
              stepD = UL_IDLE;
              unique case (stepQ)
                UL_IDLE: if (busWrData == DATA_W'(CMD_UL1) && busAddr == ADDR_UA) stepD = UL_ONE;
                UL_ONE:  if (busWrData == DATA_W'(CMD_UL2) && busAddr == ADDR_UB) stepD = UL_TWO;
                UL_TWO:  if (busWrData == DATA_W'(CMD_AUTO) && busAddr == ADDR_UA) modeD = MODE_AUTO;
                default: stepD = UL_IDLE;
              endcase
            end
          end
          MODE_AUTO: begin
            if (isQuery) begin
              modeD = MODE_QUERY;
              fromAutoD = 1'b1;
            end
          end
          default: ; // query mode: only reset is honoured
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ     <= MODE_ARRAY;
      stepQ     <= UL_IDLE;
      fromAutoQ <= 1'b0;
    end else begin
      modeQ     <= modeD;
      stepQ     <= stepD;
      fromAutoQ <= fromAutoD;
    end
  end

  assign curMode          = modeQ;
  assign readSel.selArray = modeQ == MODE_ARRAY;
  assign readSel.selAuto  = modeQ == MODE_AUTO;
  assign readSel.selQuery = modeQ == MODE_QUERY;
endmodule

// File: rtl/cfi_dpath.sv
module cfi_dpath
  import cfi_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  MFG_ID = 8'h01,
  parameter logic [7:0]  DEV_ID = 8'hC8
) (
  input  readSel_t          readSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] TAB_LO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] TAB_HI = ADDR_W'(8'h26);

  logic [7:0] tabByte;
  logic       inTable;

  assign inTable = (busAddr >= TAB_LO) && (busAddr <= TAB_HI);

  always_comb begin
    tabByte = 8'h00;
    if (inTable) begin
      unique case (busAddr[5:0])
        6'h10: tabByte = 8'h51;  // 'Q'
        6'h11: tabByte = 8'h52;  // 'R'
        6'h12: tabByte = 8'h59;  // 'Y'
        6'h13: tabByte = 8'h02;  // primary command set, low byte
        6'h15: tabByte = 8'h40;  // primary extended table pointer, low byte
        6'h1B: tabByte = 8'h27;  // supply min, volts.tenths
        6'h1C: tabByte = 8'h36;  // supply max, volts.tenths
        6'h1F: tabByte = 8'h04;  // typ write exponent (us)
        6'h21: tabByte = 8'h0A;  // typ block erase exponent (ms)
        6'h23: tabByte = 8'h05;  // max/typ write exponent
        6'h25: tabByte = 8'h04;  // max/typ block erase exponent
        default: tabByte = 8'h00;
      endcase
    end
  end

  always_comb begin
    rdData = arrayData;
    if (readSel.selQuery)     rdData = DATA_W'(tabByte);
    else if (readSel.selAuto) rdData = busAddr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFG_ID);
  end
endmodule

// File: rtl/cfi_query_resp.sv
module cfi_query_resp
  import cfi_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter int         DATA_W = 8,
  parameter logic [7:0] MFG_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  cfiMode_e curMode;
  readSel_t readSel;

  cfi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .curMode(curMode), .readSel(readSel)
  );

  cfi_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) dpath_i (
    .readSel(readSel), .busAddr(busAddr), .arrayData(arrayData), .rdData(rdData)
  );
endmodule

// File: rtl/cfi_query_chk.sv
module cfi_query_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWe,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        mode
);
  logic qryCmd, rstCmd;
  assign qryCmd = busWe && busWrData == DATA_W'(8'h98) && busAddr == ADDR_W'(12'h055);
  assign rstCmd = busWe && busWrData == DATA_W'(8'hF0);

  a_r1_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (rdData == arrayData));
  a_r2_enter_query: assert property (@(posedge clk) disable iff (!rst_n)
    (qryCmd && mode == 2'd0) |=> (mode == 2'd2));
  a_r3_auto_to_query: assert property (@(posedge clk) disable iff (!rst_n)
    (qryCmd && mode == 2'd1) |=> (mode == 2'd2));
  a_r4_reset_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    (rstCmd && mode != 2'd2) |=> (mode == 2'd0));
  a_r5_signature_q: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && busAddr == ADDR_W'(8'h10)) |-> (rdData == DATA_W'(8'h51)));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && busAddr > ADDR_W'(8'h26)) |-> (rdData == '0));
  a_r10_query_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && busWe && !rstCmd) |=> (mode == 2'd2));
endmodule

bind cfi_query_resp cfi_query_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
  .busWe(busWe), .arrayData(arrayData), .rdData(rdData), .mode(curMode)
);

// File: tb/cfi_query_resp_tb.sv
module cfi_query_resp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWe = 1'b0;
  logic [7:0]  arrayData = '0;
  logic [7:0]  rdData;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // reference state: 0 array, 1 ident, 2 query
  int refMode = 0;
  int refStep = 0;
  bit refFromId = 0;
  byte unsigned qtab[$] = '{8'h51, 8'h52, 8'h59, 8'h02, 8'h00, 8'h40, 8'h00,
                            8'h00, 8'h00, 8'h00, 8'h00, 8'h27, 8'h36, 8'h00,
                            8'h00, 8'h04, 8'h00, 8'h0A, 8'h00, 8'h05, 8'h00,
                            8'h04, 8'h00};

  always #10 clk = ~clk;

  cfi_query_resp dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .arrayData(arrayData), .rdData(rdData)
  );

  function automatic byte unsigned expRead(int a, byte unsigned arr);
    if (refMode == 0) return arr;
    if (refMode == 1) return (a % 2 == 1) ? 8'hC8 : 8'h01;
    if (a >= 16 && a < 16 + qtab.size()) return qtab[a - 16];
    return 8'h00;
  endfunction

  function automatic void refWrite(int a, int d);
    if (d == 'hF0) begin
      refMode = (refMode == 2 && refFromId) ? 1 : 0;
      refStep = 0; refFromId = 0;
    end else if (refMode == 0) begin
      if (d == 'h98 && a == 'h55) begin refMode = 2; refFromId = 0; refStep = 0; end
      else if (refStep == 0 && d == 'hAA && a == 'h555) refStep = 1;
      else if (refStep == 1 && d == 'h55 && a == 'h2AA) refStep = 2;
      else if (refStep == 2 && d == 'h90 && a == 'h555) begin refMode = 1; refStep = 0; end
      else refStep = 0;
    end else if (refMode == 1) begin
      if (d == 'h98 && a == 'h55) begin refMode = 2; refFromId = 1; end
    end
  endfunction

  // one cycle: drive, check the read of this cycle, then advance the model
  task automatic cyc(input int a, input int d, input bit we, input string tag);
    byte unsigned arr;
    byte unsigned exp;
    @(negedge clk);
    arr = byte'((a * 37 + nVec * 11) & 8'hFF);
    busAddr = 11'(a); busWrData = 8'(d); busWe = we; arrayData = arr;
    #2;
    exp = expRead(a, arr);
    nVec++;
    if (rdData !== exp) begin
      nBad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdData, exp);
    end
    if (we) refWrite(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(a, 0, 1'b0, tag);
  endtask
  task automatic wr(input int a, input int d, input string tag);
    cyc(a, d, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd('h000, "R1"); rd('h123, "R1"); rd('h7FF, "R1");
    // R2: wrong address does nothing, right one enters query next cycle (R11)
    wr('h054, 'h98, "R2"); rd('h010, "R2");
    wr('h055, 'h98, "R11"); rd('h010, "R2");
    for (int a = 'h10; a <= 'h1A; a++) rd(a, "R5");
    for (int a = 'h1B; a <= 'h1E; a++) rd(a, "R6");
    for (int a = 'h1F; a <= 'h26; a++) rd(a, "R7");
    rd('h000, "R8"); rd('h00F, "R8"); rd('h027, "R8"); rd('h555, "R8"); rd('h7FF, "R8");
    // R10: non-reset writes ignored in query
    wr('h555, 'hAA, "R10"); wr('h2AA, 'h55, "R10"); wr('h555, 'h90, "R10");
    wr('h055, 'h98, "R10"); wr('h000, 'h00, "R10");
    rd('h011, "R10"); rd('h001, "R10");
    // R4: reset at arbitrary address returns to array
    wr('h3C4, 'hF0, "R4"); rd('h010, "R4"); rd('h001, "R4");
    // R9: aborted sequences
    wr('h555, 'hAA, "R9"); wr('h2AB, 'h55, "R9"); wr('h555, 'h90, "R9"); rd('h001, "R9");
    wr('h555, 'hAA, "R9"); wr('h2AA, 'h55, "R9"); wr('h100, 'hF0, "R4"); wr('h555, 'h90, "R9"); rd('h000, "R9");
    // R9: full sequence
    wr('h555, 'hAA, "R9"); wr('h2AA, 'h55, "R9"); wr('h555, 'h90, "R11");
    rd('h000, "R9"); rd('h001, "R9"); rd('h002, "R9"); rd('h7FF, "R9");
    // R3 and R4 return-to-origin
    wr('h055, 'h98, "R3"); rd('h012, "R3"); rd('h01C, "R6");
    wr('h001, 'hF0, "R4"); rd('h000, "R4"); rd('h001, "R4");
    wr('h055, 'h98, "R3"); wr('h7FF, 'hF0, "R4"); wr('h002, 'hF0, "R4");
    rd('h001, "R4"); rd('h010, "R1");
    // back-to-back entry/exit with reads in the write cycles
    for (int k = 0; k < 20; k++) begin
      wr('h055, 'h98, "R11"); rd('h010 + k, "R11"); wr(k, 'hF0, "R11");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule